// File: doc/BRIEF.md
# Glitch-free clock stop gate

This block sits between a set of already generated clocks and the output pins. It drives nine
high-speed serial reference lanes and five bus clock lanes, and for each of them it decides whether
the clock passes or is held low. The decision combines four things: a per-lane enable field, a
stoppable attribute, a global stop condition, and six active-low clock-request pins. The stop
condition is raised either by a software run bit written to 0 or by an active-low stop pin.
Register fields steer each clock-request pin to one of a small set of reference lanes.

Every asynchronous pin is resynchronised in each lane's own clock domain by two flops. The lane's
gate register is then updated on the falling edge of that lane's clock. The gated clock is the
source clock ANDed with that register. Because the register only moves while the clock is low, a
stopped lane is held low, and the first pulse after a resume is full width. When a request pin is
enabled, it takes over a pin that normally carries a clock. The block reports that pin as an input
and keeps the clock lane that shared it off.

Top module: `clkstop_gate`

## Requirements
- R1: While rst_n is low every gated output is low.
- R2: A lane whose enable bit is 0 is held low. An enabled lane that is not stoppable, has no request routed to it and is not displaced by a request pin runs. A change of an enable or attribute field is visible from the first rising edge after the next falling edge of the lane clock.
- R3: A lane's gate changes only while its clock is low. Each output high phase is therefore whole: the output is constant across a high phase of its clock and is low whenever the clock is low.
- R4: The stop condition is active when sw_run is 0 or stop_n is 0. During a stop, every lane with its stoppable attribute at 1 is held low and every lane with the attribute at 0 keeps running. Reference lane 1 takes its attribute from stop_src1, the other reference lanes share stop_src_rest, and bus lane i uses pci_stoppable[i].
- R5: A change on stop_n or req_n that is stable before rising edge k of a lane clock shows at that lane's output from rising edge k+2. At rising edge k+1 the output still shows the old value.
- R6: Request index 0..5 is bit 0..5 of req_n and req_use. Request 0 steers to reference lane 0 when req_sel[0]=0 and to lane 2 when it is 1. Request 2 does the same with req_sel[2]. Request 1 steers to lane 1 when req_sel[1]=0 and to lane 4 when it is 1. Request 3 does the same with req_sel[3]. Request 4 always steers to lane 6 and request 5 to lane 8.
- R7: A lane with one or more enabled requests steered to it runs only while at least one of those req_n bits is 0. A request whose req_use bit is 0 has no effect. Lanes with no enabled request steered to them ignore req_n.
- R8: pin_is_input[r] equals req_use[r]. With req_use[0] set, bus lane 0 is held low, and with req_use[1] set, bus lane 1 is held low. Reference lane 3 is held low while req_use[2] or req_use[3] is set. Reference lane 7 is held low while req_use[4] or req_use[5] is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 9 | Source clocks of the reference lanes |
| pci_clk | input | 5 | Source clocks of the bus lanes |
| src_en | input | 9 | Enable per reference lane, 1 = run |
| pci_en | input | 5 | Enable per bus lane, 1 = run |
| stop_src1 | input | 1 | Stoppable attribute of reference lane 1 |
| stop_src_rest | input | 1 | Stoppable attribute shared by the other reference lanes |
| pci_stoppable | input | 5 | Stoppable attribute per bus lane |
| sw_run | input | 1 | Software run bit, 0 = stop stoppable lanes |
| stop_n | input | 1 | Asynchronous stop pin, active low |
| req_n | input | 6 | Asynchronous clock-request pins, active low |
| req_use | input | 6 | Enable per request pin |
| req_sel | input | 4 | Steering select for requests 0 to 3 |
| src_clk_o | output | 9 | Gated reference clocks |
| pci_clk_o | output | 5 | Gated bus clocks |
| pin_is_input | output | 6 | Direction of each shared request pin, 1 = input |

## Verification
The hardest case to reach from the ports is two enabled requests landing on the same lane. Requests 0 and 2 can both steer to lane 0 or lane 2, and requests 1 and 3 to lane 1 or lane 4. In that case a stop and a request resolve together on a lane that is also displaced or disabled. Directed passes walk every request through both select values. A random phase then draws use, select, pin and attribute bits together, so overlapping steering and mid-synchroniser stops occur often. After each change, the bench samples every output twice inside each clock high phase and once inside each low phase until the new state has settled.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
  localparam int REQ_CNT = 6;   // clock-request pins
  localparam int SEL_CNT = 4;   // requests with a steering select bit

  // Lane index a request pin is steered to.
  function automatic int req_target(input int r, input logic sel);
    case (r)
      0, 2:    return sel ? 2 : 0;
      1, 3:    return sel ? 4 : 1;
      4:       return 6;
      default: return 8;
    endcase
  endfunction

  // Run decision of one lane.
  function automatic logic lane_run(input logic en, input logic forced,
                                    input logic halt, input logic routed_any,
                                    input logic granted);
    return en & ~forced & ~halt & (~routed_any | granted);
  endfunction
endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
  parameter int   WIDTH   = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {WIDTH{RST_VAL}};
      sync_q <= {WIDTH{RST_VAL}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/clkstop_route.sv
`timescale 1ns/1ps
module clkstop_route import clkstop_pkg::*; #(
  parameter int NUM_SRC = 9,
  parameter int NUM_PCI = 5,
  localparam int N_LANE = NUM_SRC + NUM_PCI
) (
  input  logic [REQ_CNT-1:0]              req_use,
  input  logic [SEL_CNT-1:0]              req_sel,
  input  logic                            stop_src1,
  input  logic                            stop_src_rest,
  input  logic [NUM_PCI-1:0]              pci_stoppable,
  output logic [N_LANE-1:0][REQ_CNT-1:0]  route_mask,
  output logic [N_LANE-1:0]               lane_forced,
  output logic [N_LANE-1:0]               lane_stoppable
);
  logic [REQ_CNT-1:0] sel_ext;
  assign sel_ext = {{(REQ_CNT-SEL_CNT){1'b0}}, req_sel};

  // steering of the request pins onto lanes
  always_comb begin
    route_mask = '0;
    for (int r = 0; r < REQ_CNT; r++) begin
      if (req_use[r]) route_mask[req_target(r, sel_ext[r])][r] = 1'b1;
    end
  end

  // lanes whose pin is taken over by a request input
  always_comb begin
    lane_forced            = '0;
    lane_forced[NUM_SRC]   = req_use[0];
    lane_forced[NUM_SRC+1] = req_use[1];
    lane_forced[3]         = req_use[2] | req_use[3];
    lane_forced[7]         = req_use[4] | req_use[5];
  end

  for (genvar i = 0; i < N_LANE; i++) begin : g_attr
    if (i == 1) begin : g_src1
      assign lane_stoppable[i] = stop_src1;
    end else if (i < NUM_SRC) begin : g_src
      assign lane_stoppable[i] = stop_src_rest;
    end else begin : g_pci
      assign lane_stoppable[i] = pci_stoppable[i-NUM_SRC];
    end
  end
endmodule

// File: rtl/clkstop_lane.sv
`timescale 1ns/1ps
module clkstop_lane import clkstop_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_n,
  input  logic [REQ_CNT-1:0] req_n_a,
  input  logic               stop_n_a,
  input  logic               en,
  input  logic               forced,
  input  logic               stoppable,
  input  logic               sw_run,
  input  logic [REQ_CNT-1:0] route,
  output logic               clk_o,
  output logic               gate_o,
  output logic               halt_o
);
  logic [REQ_CNT-1:0] req_n_s;
  logic               stop_n_s;
  logic               granted;
  logic               want;
  logic               gate_q;

  clkstop_sync #(.WIDTH(REQ_CNT+1), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .d_i   ({stop_n_a, req_n_a}),
    .q_o   ({stop_n_s, req_n_s})
  );

  assign halt_o  = stoppable & (~sw_run | ~stop_n_s);
  assign granted = |(route & ~req_n_s);
  assign want    = lane_run(en, forced, halt_o, |route, granted);

  // gate moves only while the clock is low
  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= want;
  end

  assign gate_o = gate_q;
  assign clk_o  = clk_i & gate_q;
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate import clkstop_pkg::*; #(
  parameter int NUM_SRC = 9,
  parameter int NUM_PCI = 5
) (
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic [NUM_PCI-1:0] pci_clk,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_PCI-1:0] pci_en,
  input  logic               stop_src1,
  input  logic               stop_src_rest,
  input  logic [NUM_PCI-1:0] pci_stoppable,
  input  logic               sw_run,
  input  logic               stop_n,
  input  logic [REQ_CNT-1:0] req_n,
  input  logic [REQ_CNT-1:0] req_use,
  input  logic [SEL_CNT-1:0] req_sel,
  output logic [NUM_SRC-1:0] src_clk_o,
  output logic [NUM_PCI-1:0] pci_clk_o,
  output logic [REQ_CNT-1:0] pin_is_input
);
  localparam int N_LANE = NUM_SRC + NUM_PCI;

  logic [N_LANE-1:0]              lane_clk;
  logic [N_LANE-1:0]              lane_en;
  logic [N_LANE-1:0]              lane_out;
  logic [N_LANE-1:0]              lane_gate;
  logic [N_LANE-1:0]              lane_halt;
  logic [N_LANE-1:0]              lane_forced;
  logic [N_LANE-1:0]              lane_stoppable;
  logic [N_LANE-1:0]              lane_free;
  logic [N_LANE-1:0][REQ_CNT-1:0] route_mask;

  assign lane_clk = {pci_clk, src_clk};
  assign lane_en  = {pci_en, src_en};

  clkstop_route #(.NUM_SRC(NUM_SRC), .NUM_PCI(NUM_PCI)) u_route (
    .req_use        (req_use),
    .req_sel        (req_sel),
    .stop_src1      (stop_src1),
    .stop_src_rest  (stop_src_rest),
    .pci_stoppable  (pci_stoppable),
    .route_mask     (route_mask),
    .lane_forced    (lane_forced),
    .lane_stoppable (lane_stoppable)
  );

  for (genvar i = 0; i < N_LANE; i++) begin : g_lane
    clkstop_lane u_lane (
      .clk_i     (lane_clk[i]),
      .rst_n     (rst_n),
      .req_n_a   (req_n),
      .stop_n_a  (stop_n),
      .en        (lane_en[i]),
      .forced    (lane_forced[i]),
      .stoppable (lane_stoppable[i]),
      .sw_run    (sw_run),
      .route     (route_mask[i]),
      .clk_o     (lane_out[i]),
      .gate_o    (lane_gate[i]),
      .halt_o    (lane_halt[i])
    );
    // lane that nothing may stop: named for the checker
    assign lane_free[i] = lane_en[i] & ~lane_forced[i] & ~lane_stoppable[i]
                        & ~(|route_mask[i]);
  end

  assign src_clk_o    = lane_out[NUM_SRC-1:0];
  assign pci_clk_o    = lane_out[N_LANE-1:NUM_SRC];
  assign pin_is_input = req_use;
endmodule

// File: rtl/clkstop_gate_chk.sv
`timescale 1ns/1ps
module clkstop_gate_chk #(
  parameter int N_LANE = 14
) (
  input logic              rst_n,
  input logic [N_LANE-1:0] lane_clk,
  input logic [N_LANE-1:0] lane_gate,
  input logic [N_LANE-1:0] lane_en,
  input logic [N_LANE-1:0] lane_forced,
  input logic [N_LANE-1:0] lane_halt,
  input logic [N_LANE-1:0] lane_free
);
  for (genvar i = 0; i < N_LANE; i++) begin : g_chk
    p_disabled_low_r2: assert property (@(posedge lane_clk[i]) disable iff (!rst_n)
      (!lane_en[i] && $past(!lane_en[i])) |-> !lane_gate[i])
      else $error("lane %0d runs while disabled", i);

    p_free_runs_r2: assert property (@(posedge lane_clk[i]) disable iff (!rst_n)
      (lane_free[i] && $past(lane_free[i])) |-> lane_gate[i])
      else $error("lane %0d stopped although free running", i);

    p_halt_low_r4: assert property (@(posedge lane_clk[i]) disable iff (!rst_n)
      (lane_halt[i] && $past(lane_halt[i])) |-> !lane_gate[i])
      else $error("lane %0d runs during stop", i);

    p_forced_low_r8: assert property (@(posedge lane_clk[i]) disable iff (!rst_n)
      (lane_forced[i] && $past(lane_forced[i])) |-> !lane_gate[i])
      else $error("lane %0d runs while its pin is an input", i);

    always @(posedge lane_gate[i] or negedge lane_gate[i]) begin
      if (rst_n) begin
        p_gate_edge_low_r3: assert (lane_clk[i] == 1'b0)
          else $error("lane %0d gate moved while clock high", i);
      end
    end
  end
endmodule

bind clkstop_gate clkstop_gate_chk #(.N_LANE(N_LANE)) u_chk (
  .rst_n       (rst_n),
  .lane_clk    (lane_clk),
  .lane_gate   (lane_gate),
  .lane_en     (lane_en),
  .lane_forced (lane_forced),
  .lane_halt   (lane_halt),
  .lane_free   (lane_free)
);

// File: tb/clkstop_gate_bench.sv
`timescale 1ns/1ps
module clkstop_gate_bench;
  localparam int NS = 9;
  localparam int NP = 5;
  localparam int NL = NS + NP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_en = '1;
  logic [NP-1:0] pci_en = '1;
  logic          stop_src1 = 1'b0;
  logic          stop_src_rest = 1'b0;
  logic [NP-1:0] pci_stoppable = '0;
  logic          sw_run = 1'b1;
  logic          stop_n = 1'b1;
  logic [5:0]    req_n = '1;
  logic [5:0]    req_use = '0;
  logic [3:0]    req_sel = '0;
  logic [NS-1:0] src_clk_o;
  logic [NP-1:0] pci_clk_o;
  logic [5:0]    pin_is_input;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  clkstop_gate u_clkstop_gate (
    .rst_n (rst_n), .src_clk ({NS{clk}}), .pci_clk ({NP{clk}}),
    .src_en (src_en), .pci_en (pci_en), .stop_src1 (stop_src1),
    .stop_src_rest (stop_src_rest), .pci_stoppable (pci_stoppable),
    .sw_run (sw_run), .stop_n (stop_n), .req_n (req_n), .req_use (req_use),
    .req_sel (req_sel), .src_clk_o (src_clk_o), .pci_clk_o (pci_clk_o),
    .pin_is_input (pin_is_input)
  );

  function automatic int dest(int r);
    if (r == 4) return 6;
    if (r == 5) return 8;
    if (r == 0 || r == 2) return req_sel[r] ? 2 : 0;
    return req_sel[r] ? 4 : 1;
  endfunction

  function automatic bit exp_lane(int lane);
    bit stop_now, stoppable, forced, enabled, any_route, any_grant;
    stop_now = !sw_run || !stop_n;
    if (lane < NS) stoppable = (lane == 1) ? stop_src1 : stop_src_rest;
    else           stoppable = pci_stoppable[lane-NS];
    enabled = (lane < NS) ? src_en[lane] : pci_en[lane-NS];
    forced = (lane == NS && req_use[0]) || (lane == NS+1 && req_use[1]) ||
             (lane == 3 && (req_use[2] || req_use[3])) ||
             (lane == 7 && (req_use[4] || req_use[5]));
    any_route = 0;
    any_grant = 0;
    for (int r = 0; r < 6; r++) begin
      if (req_use[r] && dest(r) == lane) begin
        any_route = 1;
        if (!req_n[r]) any_grant = 1;
      end
    end
    if (!enabled || forced) return 0;
    if (stoppable && stop_now) return 0;
    if (any_route && !any_grant) return 0;
    return 1;
  endfunction

  task automatic expect_vec(string req, string what, logic [NL-1:0] act, logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_lanes(string req);
    logic [NL-1:0] exp;
    for (int l = 0; l < NL; l++) exp[l] = exp_lane(l);
    expect_vec(req, "outputs", {pci_clk_o, src_clk_o}, exp);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // R3: output constant through each high phase and low in each low phase
  task automatic glitch_watch(int n);
    logic [NL-1:0] a;
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      #0.5 a = {pci_clk_o, src_clk_o};
      #1   expect_vec("R3", "high phase stable", {pci_clk_o, src_clk_o}, a);
      #1   expect_vec("R3", "low phase", {pci_clk_o, src_clk_o}, '0);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset holds everything low
    step(3);
    expect_vec("R1", "during reset", {pci_clk_o, src_clk_o}, '0);
    rst_n = 1'b1;
    step(3);
    check_lanes("R2 defaults all running");

    // R2: enable fields, visible one edge later
    src_en = 9'b101010101; pci_en = 5'b01101;
    step(1);
    check_lanes("R2 enables");
    src_en = '1; pci_en = '1;
    step(1);
    check_lanes("R2 re-enable");

    // R4: software stop with mixed attributes
    stop_src1 = 1'b1; pci_stoppable = 5'b10110;
    sw_run = 1'b0;
    step(1);
    check_lanes("R4 sw stop src1 only");
    stop_src_rest = 1'b1; stop_src1 = 1'b0;
    step(1);
    check_lanes("R4 sw stop rest");
    sw_run = 1'b1;
    step(1);
    check_lanes("R4 sw resume");

    // R5: stop pin latency on lane 0 (stoppable via stop_src_rest)
    stop_n = 1'b0;
    step(2);
    expect_vec("R5", "stop edge k+1", {13'd0, src_clk_o[0]}, 14'd1);
    step(1);
    expect_vec("R5", "stop edge k+2", {13'd0, src_clk_o[0]}, 14'd0);
    check_lanes("R4 pin stop");
    stop_n = 1'b1;
    step(2);
    expect_vec("R5", "resume edge k+1", {13'd0, src_clk_o[0]}, 14'd0);
    step(1);
    expect_vec("R5", "resume edge k+2", {13'd0, src_clk_o[0]}, 14'd1);
    stop_src_rest = 1'b0; pci_stoppable = '0;

    // R6/R7: each request through each select value
    for (int r = 0; r < 6; r++) begin
      for (int s = 0; s < 2; s++) begin
        req_use = 6'(1 << r);
        req_sel = s[0] ? 4'hf : 4'h0;
        req_n = '1;
        step(3);
        check_lanes("R6 request idle");
        expect_vec("R8", "pin dir", {8'd0, pin_is_input}, {8'd0, req_use});
        req_n[r] = 1'b0;
        step(3);
        check_lanes("R7 request granted");
      end
    end
    // R7: disabled request ignored
    req_use = '0; req_n = '0;
    step(3);
    check_lanes("R7 unused requests");
    // R8: all pins as inputs, A and C both on lane 2
    req_use = '1; req_sel = 4'b0101; req_n = 6'b111011;
    step(3);
    check_lanes("R8 all requests");
    expect_vec("R8", "pin dir all", {8'd0, pin_is_input}, {8'd0, 6'h3f});

    // random phase covering R2, R3, R4, R6, R7, R8
    for (int it = 0; it < 200; it++) begin
      src_en        = NS'($urandom | $urandom);
      pci_en        = NP'($urandom | $urandom);
      stop_src1     = 1'($urandom);
      stop_src_rest = 1'($urandom);
      pci_stoppable = NP'($urandom);
      sw_run        = ($urandom % 4) != 0;
      stop_n        = ($urandom % 3) != 0;
      req_n         = 6'($urandom);
      req_use       = 6'($urandom & $urandom);
      req_sel       = 4'($urandom);
      glitch_watch(3);
      check_lanes("R7 random");
      expect_vec("R8", "random pin dir", {8'd0, pin_is_input}, {8'd0, req_use});
    end
    finish_run();
  end
endmodule